// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is one 8-bit input port of a parallel peripheral interface running in its strobed input mode. A peripheral places a byte on the port pins and pulses an active-low strobe. While the strobe is low the port captures the pins into its holding register. On the strobe's falling edge it raises an input-buffer-full flag back to the peripheral. Once the strobe has returned high, and if the port's interrupt enable is set, it raises an interrupt request toward the CPU.

The CPU fetches the byte with an active-low read while the port is selected. During the read the held byte is driven onto the CPU data bus. The falling edge of the read withdraws the interrupt request, and the rising edge empties the buffer. The interrupt enable is a single flip-flop written by the port C bit set/reset command. A parameter chooses the port A or port B pin assignment, and with it the port C bit that addresses the enable.

The strobe comes from the peripheral asynchronously and passes through a synchronizer. The read and bit set/reset inputs come from the CPU side and are taken as synchronous to the clock. The reset is asynchronous and active low, and its release is synchronized inside the block.

Top module: `strobed_in_port`

## Requirements
- R1: After reset, ibf, intr and inte are 0 and dbus_oe is 0. A read issued before any strobe returns 8'h00 on dbus_out.
- R2: While the synchronized strobe is low and strobed_in_en is 1, the pins are copied into the holding register. ibf goes to 1 on the SYNC_STAGES+1 rising clock edge after stb_n falls.
- R3: intr goes to 1 only when stb_n has returned high, ibf is 1 and inte is 1. It rises SYNC_STAGES+1 edges after stb_n rises, and it stays 0 while stb_n is low. Whenever intr is 1, ibf is 1.
- R4: A read is active when cs is 1 and rd_n is 0. The first edge after a read becomes active clears intr, and intr does not set again while the read lasts. ibf stays 1 during the read.
- R5: The first edge after an active read ends clears ibf.
- R6: While a read is active, dbus_oe is 1 and dbus_out carries the held byte. Otherwise dbus_oe is 0 and dbus_out is 8'h00. Pin changes after the strobe has ended do not alter the held byte.
- R7: A bit set/reset command (bsr_we=1) whose bsr_bit equals the enable index writes bsr_set into inte on the next edge. The enable index is 4 for port A (PORT_SEL=PORT_A) and 2 for port B. Commands naming any other bit leave inte unchanged.
- R8: While inte is 0, intr stays 0. Clearing inte while intr is 1 drops intr on the following edge.
- R9: While strobed_in_en is 0, ibf and intr are held at 0, strobes are ignored, and ibf already set is cleared on the next edge.
- R10: A read pulse with cs at 0 leaves ibf and intr unchanged and keeps dbus_oe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobed_in_en | input | 1 | Port configured as strobed input (direction bit 1) |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| pin_data | input | DATA_W | Port pins from the peripheral |
| cs | input | 1 | Port selected by the CPU address decode |
| rd_n | input | 1 | CPU read, active low |
| bsr_we | input | 1 | Port C bit set/reset command valid |
| bsr_bit | input | 3 | Port C bit addressed by the command |
| bsr_set | input | 1 | 1 sets, 0 clears the addressed bit |
| ibf | output | 1 | Input buffer full, to the peripheral |
| intr | output | 1 | Interrupt request to the CPU |
| inte | output | 1 | Interrupt enable flip-flop |
| dbus_out | output | DATA_W | Byte toward the CPU data bus |
| dbus_oe | output | 1 | CPU data bus output enable |

## Verification
Results on the strobe side are due SYNC_STAGES+1 edges after a stb_n change, which is three with the default. The bench waits four falling clock edges before sampling ibf or intr, and it holds the pins steady through that window. Results on the read side are due one edge after rd_n changes, and an enable write takes effect one edge after its command. The bench samples these at the next falling edge. The bus outputs are combinational from the read, so they are checked 1 ns after rd_n is driven, inside the same half cycle.

// File: rtl/sip_pkg.sv
package sip_pkg;

  // Which pin assignment the port instance uses.
  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_id_e;

  // Port C bit whose set/reset command writes the interrupt enable.
  function automatic int unsigned inte_index(port_id_e p);
    return (p == PORT_A) ? 4 : 2;
  endfunction

endpackage

// File: rtl/sip_sync.sv
// Shift-register synchronizer; STAGES must be 2 or more.
module sip_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sip_capture.sv
// Data holding register and input-buffer-full flag.
module sip_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              stb_s,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] pin_data,
  output logic              ibf,
  output logic [DATA_W-1:0] hold_q
);

  logic              stb_d_q;
  logic              rd_d_q;
  logic              ibf_q;
  logic              ibf_d;
  logic              stb_fall;
  logic              rd_rise;
  logic              hold_en;
  logic [DATA_W-1:0] hold_d;

  always_comb begin
    stb_fall = stb_d_q & ~stb_s;
    rd_rise  = rd_d_q & ~rd_sel;
    hold_en  = mode_en & ~stb_s;
    hold_d   = pin_data;
    if (!mode_en)      ibf_d = 1'b0;
    else if (stb_fall) ibf_d = 1'b1;
    else if (rd_rise)  ibf_d = 1'b0;
    else               ibf_d = ibf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d_q <= 1'b1;
      rd_d_q  <= 1'b0;
      ibf_q   <= 1'b0;
    end else begin
      stb_d_q <= stb_s;
      rd_d_q  <= rd_sel;
      ibf_q   <= ibf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign ibf = ibf_q;

  // R2: a strobe fall in strobed mode fills the buffer
  p_ibf_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_s) && mode_en) |=> ibf_q);

  // R5: end of a read empties the buffer unless a new strobe arrives
  p_ibf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_sel) && mode_en && !$fell(stb_s)) |=> !ibf_q);

  // R9: leaving strobed mode empties the buffer
  p_mode_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !ibf_q);

endmodule

// File: rtl/sip_irq.sv
// Interrupt enable flip-flop and interrupt request flip-flop.
module sip_irq #(
  parameter int unsigned INTE_BIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_en,
  input  logic       stb_s,
  input  logic       ibf,
  input  logic       rd_sel,
  input  logic       bsr_we,
  input  logic [2:0] bsr_bit,
  input  logic       bsr_set,
  output logic       inte,
  output logic       intr
);

  localparam logic [2:0] INTE_IDX = 3'(INTE_BIT);

  logic inte_q;
  logic inte_d;
  logic intr_q;
  logic intr_d;
  logic cond_q;
  logic cond;
  logic rd_d_q;
  logic inte_hit;
  logic rd_fall;
  logic intr_set;

  always_comb begin
    inte_hit = bsr_we && (bsr_bit == INTE_IDX);
    inte_d   = inte_hit ? bsr_set : inte_q;
    cond     = stb_s & ibf & inte_q;
    rd_fall  = rd_sel & ~rd_d_q;
    // set on the condition's rising edge, never inside a read
    intr_set = cond & ~cond_q & ~rd_sel & ~rd_d_q;
    if (!mode_en || !inte_q || rd_fall) intr_d = 1'b0;
    else if (intr_set)                  intr_d = 1'b1;
    else                                intr_d = intr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inte_q <= 1'b0;
      intr_q <= 1'b0;
      cond_q <= 1'b0;
      rd_d_q <= 1'b0;
    end else begin
      inte_q <= inte_d;
      intr_q <= intr_d;
      cond_q <= cond;
      rd_d_q <= rd_sel;
    end
  end

  assign inte = inte_q;
  assign intr = intr_q;

  // R4: a read starting drops the request
  p_intr_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_sel) |=> !intr_q);

  // R7: a command on the enable bit writes the enable
  p_inte_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_we && (bsr_bit == INTE_IDX)) |=> (inte_q == $past(bsr_set)));

  // R8: no request survives a cleared enable
  p_no_intr_without_inte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inte_q |=> !intr_q);

endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
  import sip_pkg::*;
#(
  parameter port_id_e    PORT_SEL    = PORT_A,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobed_in_en,
  input  logic              stb_n,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              cs,
  input  logic              rd_n,
  input  logic              bsr_we,
  input  logic [2:0]        bsr_bit,
  input  logic              bsr_set,
  output logic              ibf,
  output logic              intr,
  output logic              inte,
  output logic [DATA_W-1:0] dbus_out,
  output logic              dbus_oe
);

  localparam int unsigned INTE_BIT = inte_index(PORT_SEL);

  logic              rst_s_n;
  logic              stb_s;
  logic              rd_sel;
  logic [DATA_W-1:0] hold_q;

  // reset: asserted asynchronously, released on the clock
  sip_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_s_n)
  );

  // peripheral strobe: idles high
  sip_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     (stb_n),
    .q     (stb_s)
  );

  assign rd_sel = cs & ~rd_n;

  sip_capture #(.DATA_W(DATA_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mode_en  (strobed_in_en),
    .stb_s    (stb_s),
    .rd_sel   (rd_sel),
    .pin_data (pin_data),
    .ibf      (ibf),
    .hold_q   (hold_q)
  );

  sip_irq #(.INTE_BIT(INTE_BIT)) u_irq (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .mode_en (strobed_in_en),
    .stb_s   (stb_s),
    .ibf     (ibf),
    .rd_sel  (rd_sel),
    .bsr_we  (bsr_we),
    .bsr_bit (bsr_bit),
    .bsr_set (bsr_set),
    .inte    (inte),
    .intr    (intr)
  );

  always_comb begin
    dbus_oe  = rd_sel;
    dbus_out = rd_sel ? hold_q : '0;
  end

  // R3: a request is only raised over a full buffer
  p_intr_needs_ibf_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    intr |-> ibf);

  // R6: the bus is quiet outside a read
  p_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !dbus_oe |-> (dbus_out == '0));

endmodule

// File: tb/strobed_in_port_tb.sv
module strobed_in_port_tb;
  import sip_pkg::*;

  localparam port_id_e    TB_PORT  = PORT_A;
  localparam logic [2:0]  TB_INTE  = (TB_PORT == PORT_A) ? 3'd4 : 3'd2;  // R7
  localparam logic [2:0]  TB_OTHER = 3'd6;

  // {data[7:0], inte_on, exp_ibf, exp_intr}
  localparam int NVEC = 5;
  localparam logic [10:0] VEC [NVEC] = '{
    {8'hA5, 1'b1, 1'b1, 1'b1},
    {8'h3C, 1'b0, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b1, 1'b0},
    {8'h81, 1'b1, 1'b1, 1'b1}
  };

  logic       clk;
  logic       rst_n;
  logic       strobed_in_en;
  logic       stb_n;
  logic [7:0] pin_data;
  logic       cs;
  logic       rd_n;
  logic       bsr_we;
  logic [2:0] bsr_bit;
  logic       bsr_set;
  logic       ibf;
  logic       intr;
  logic       inte;
  logic [7:0] dbus_out;
  logic       dbus_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  strobed_in_port #(.PORT_SEL(TB_PORT), .DATA_W(8), .SYNC_STAGES(2)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobed_in_en (strobed_in_en),
    .stb_n         (stb_n),
    .pin_data      (pin_data),
    .cs            (cs),
    .rd_n          (rd_n),
    .bsr_we        (bsr_we),
    .bsr_bit       (bsr_bit),
    .bsr_set       (bsr_set),
    .ibf           (ibf),
    .intr          (intr),
    .inte          (inte),
    .dbus_out      (dbus_out),
    .dbus_oe       (dbus_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bsr(input logic [2:0] b, input logic s);
    @(negedge clk);
    bsr_we = 1'b1; bsr_bit = b; bsr_set = s;
    @(negedge clk);
    bsr_we = 1'b0;
  endtask

  // strobe a byte in and release; ibf is sampled while the strobe is low
  task automatic strobe(input logic [7:0] d, input logic exp_ibf, input string tag);
    @(negedge clk);
    pin_data = d; stb_n = 1'b0;
    tick(4);
    chk({tag, " ibf during strobe"}, {7'd0, ibf}, {7'd0, exp_ibf});
    chk({tag, " intr low during strobe"}, {7'd0, intr}, 8'd0);
    stb_n = 1'b1;
    tick(4);
  endtask

  // read cycle; checks the bus, intr drop and ibf drop
  task automatic read_byte(input logic [7:0] exp_d, input string tag);
    cs = 1'b1; rd_n = 1'b0;
    #1;
    chk({tag, " R6 oe"}, {7'd0, dbus_oe}, 8'd1);
    chk({tag, " R6 data"}, dbus_out, exp_d);
    tick(1);
    chk({tag, " R4 intr cleared"}, {7'd0, intr}, 8'd0);
    chk({tag, " R4 ibf held"}, {7'd0, ibf}, 8'd1);
    rd_n = 1'b1;
    #1;
    chk({tag, " R6 oe off"}, {7'd0, dbus_oe}, 8'd0);
    tick(1);
    chk({tag, " R5 ibf cleared"}, {7'd0, ibf}, 8'd0);
    cs = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; strobed_in_en = 1'b1; stb_n = 1'b1; pin_data = 8'h00;
    cs = 1'b0; rd_n = 1'b1; bsr_we = 1'b0; bsr_bit = 3'd0; bsr_set = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk("R1 ibf", {7'd0, ibf}, 8'd0);
    chk("R1 intr", {7'd0, intr}, 8'd0);
    chk("R1 inte", {7'd0, inte}, 8'd0);
    chk("R1 oe", {7'd0, dbus_oe}, 8'd0);
    chk("R1 bus", dbus_out, 8'd0);
    cs = 1'b1; rd_n = 1'b0;
    #1;
    chk("R1 latch zero", dbus_out, 8'h00);
    tick(1);
    rd_n = 1'b1; cs = 1'b0;
    tick(1);
    chk("R1 ibf after read", {7'd0, ibf}, 8'd0);

    // R7 enable addressing
    bsr(TB_OTHER, 1'b1);
    chk("R7 other bit ignored", {7'd0, inte}, 8'd0);
    bsr(TB_INTE, 1'b1);
    chk("R7 enable set", {7'd0, inte}, 8'd1);
    bsr(TB_OTHER, 1'b0);
    chk("R7 other bit clear ignored", {7'd0, inte}, 8'd1);
    bsr(TB_INTE, 1'b0);
    chk("R7 enable cleared", {7'd0, inte}, 8'd0);

    // vector table: R2, R3, R4, R5, R6, R8
    for (int i = 0; i < NVEC; i++) begin
      bsr(TB_INTE, VEC[i][2]);
      strobe(VEC[i][10:3], VEC[i][1], $sformatf("R2 vec%0d", i));
      chk($sformatf("R3 vec%0d intr", i), {7'd0, intr}, {7'd0, VEC[i][0]});
      pin_data = ~VEC[i][10:3];
      read_byte(VEC[i][10:3], $sformatf("vec%0d", i));
    end

    // R8 clearing the enable drops a pending request
    bsr(TB_INTE, 1'b1);
    strobe(8'h5A, 1'b1, "R8 setup");
    chk("R8 intr before clear", {7'd0, intr}, 8'd1);
    bsr(TB_INTE, 1'b0);
    tick(1);
    chk("R8 intr after clear", {7'd0, intr}, 8'd0);
    chk("R8 ibf kept", {7'd0, ibf}, 8'd1);
    read_byte(8'h5A, "R8 drain");

    // R10 unselected read
    strobe(8'h77, 1'b1, "R10 setup");
    cs = 1'b0; rd_n = 1'b0;
    #1;
    chk("R10 oe off", {7'd0, dbus_oe}, 8'd0);
    chk("R10 bus quiet", dbus_out, 8'd0);
    tick(1);
    rd_n = 1'b1;
    tick(2);
    chk("R10 ibf kept", {7'd0, ibf}, 8'd1);
    read_byte(8'h77, "R10 drain");

    // R9 strobed mode off
    strobed_in_en = 1'b0;
    strobe(8'h12, 1'b0, "R9 ignored");
    chk("R9 ibf stays low", {7'd0, ibf}, 8'd0);
    strobed_in_en = 1'b1;
    strobe(8'h34, 1'b1, "R9 setup");
    strobed_in_en = 1'b0;
    tick(2);
    chk("R9 ibf cleared", {7'd0, ibf}, 8'd0);
    strobed_in_en = 1'b1;
    tick(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule